// File: doc/BRIEF.md
# Flash Option Byte Protection Unit

This unit turns the option half-words kept in flash into the read-protect and write-protect flags the rest of the chip obeys. Each option value sits in the low byte of a half-word, and the high byte holds its bitwise inverse. The unit checks that pairing and decodes the values. It copies the result into its output registers only when the chip reset strobe fires. Between strobes the stored half-words may be rewritten freely, and the outputs do not change, so other flash work can carry on after the option bytes have been updated.

The unit also runs the protection-disable sequence. On request it asks the flash controller to erase the option page. It then asks for one half-word write that puts the open value into the read-protect cell. After the erase, every write-protect byte reads 0xFF, so clearing read protection also clears write protection.

The sequencer is a three-state machine:
- `ST_IDLE` moves to `ST_ERASE` when a disable request arrives.
- `ST_ERASE` moves to `ST_WRITE` when the controller acknowledges.
- `ST_WRITE` moves back to `ST_IDLE` when the controller acknowledges.
- The reset strobe sends any state straight to `ST_IDLE`.

Top module: `optb_prot_unit`

## Requirements
- R1: A half-word is valid when bits 15:8 equal the bitwise inverse of bits 7:0. The value is bits 7:0. The erased pattern 16'hFFFF is also valid and reads as value 8'hFF.
- R2: After a latch, rd_prot is 0 only if the read half-word is valid with value 8'hA5 (pattern 16'h5AA5). Any other valid value sets rd_prot to 1, including the erased value 8'hFF and 8'h00 (pattern 16'hFF00).
- R3: If the read half-word is not a valid pair, the latch sets rd_prot to 1 and pair_err to 1.
- R4: Write-protect byte k is the half-word at wp_hw[16k+15:16k]. If the pair is valid, wr_prot[8k+i] is 1 exactly when bit i of its value is 0. If the pair is invalid, all eight bits wr_prot[8k+7:8k] are 1 and pair_err is 1.
- R5: rd_prot, wr_prot and pair_err change only on the clock edge that samples latch_stb high. Changes to the stored half-words at any other time have no effect on them.
- R6: After rst_n, rd_prot, wr_prot and pair_err are all 0 until the first latch.
- R7: dis_req sampled in ST_IDLE starts the disable sequence. pgm_erase is held until an edge samples pgm_ack high. Then pgm_write is held, with pgm_data = 16'h5AA5 aimed at the read-protect cell, until the next acknowledge. The unit then returns to idle. dis_busy is 1 from the cycle after the request until that final acknowledge.
- R8: pgm_erase and pgm_write are never 1 together.
- R9: latch_stb aborts the disable sequence. In the following cycle dis_busy, pgm_erase and pgm_write are all 0.
- R10: dis_req is ignored while the sequence is running. It neither restarts nor extends the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the unit |
| latch_stb | input | 1 | Chip reset event; latches protection and aborts the sequence |
| rd_hw | input | 16 | Stored read-protect half-word |
| wp_hw | input | NUM_WP*16 | Stored write-protect half-words, byte k at [16k+15:16k] |
| dis_req | input | 1 | Request to run the protection-disable sequence |
| pgm_ack | input | 1 | Flash controller acknowledge of the current erase or write |
| rd_prot | output | 1 | Effective read protection |
| wr_prot | output | NUM_WP*8 | Effective write protection, one bit per region, 1 = protected |
| pair_err | output | 1 | Some half-word failed the inverse pairing at the last latch |
| dis_busy | output | 1 | Disable sequence in progress |
| pgm_erase | output | 1 | Option page erase request |
| pgm_write | output | 1 | Read-protect cell write request |
| pgm_data | output | 16 | Half-word to write during pgm_write |

## Verification
The bench builds the unit with NUM_WP = 2. That gives a 16-bit region vector, so each region bit and each byte boundary can be checked against a literal. It also lets a pairing fault be placed in the upper byte alone while the lower byte stays clean. The acknowledge is held back for several cycles, which exposes the hold behaviour of each request. A stray disable request during the write phase and a latch strobe in the middle of an erase cover the ignore and abort paths.

// File: rtl/optb_pkg.sv
package optb_pkg;
    localparam int HW_W   = 16;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] RD_OPEN_VAL  = 8'hA5;
    localparam logic [BYTE_W-1:0] MISMATCH_VAL = 8'h00;
    localparam logic [HW_W-1:0]   ERASED_HW    = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

    function automatic logic [HW_W-1:0] pack_pair(input logic [BYTE_W-1:0] v);
        return {~v, v};
    endfunction
endpackage

// File: rtl/optb_pair_decode.sv
module optb_pair_decode
    import optb_pkg::*;
(
    input  logic [HW_W-1:0]   hw,
    output logic [BYTE_W-1:0] val,
    output logic              ok
);
    logic paired;
    logic erased;

    always_comb begin
        paired = (hw[HW_W-1:BYTE_W] == ~hw[BYTE_W-1:0]);
        erased = (hw == ERASED_HW);
        ok     = paired || erased;
        val    = ok ? hw[BYTE_W-1:0] : MISMATCH_VAL;
    end
endmodule

// File: rtl/optb_latch.sv
module optb_latch
    import optb_pkg::*;
#(
    parameter int NUM_WP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     latch_stb,
    input  logic [BYTE_W-1:0]        rd_val,
    input  logic                     rd_ok,
    input  logic [NUM_WP*BYTE_W-1:0] wp_val,
    input  logic [NUM_WP-1:0]        wp_ok,
    output logic                     rd_prot,
    output logic [NUM_WP*BYTE_W-1:0] wr_prot,
    output logic                     pair_err
);
    logic                     rd_prot_d;
    logic [NUM_WP*BYTE_W-1:0] wr_prot_d;
    logic                     err_d;

    always_comb begin
        rd_prot_d = !(rd_ok && (rd_val == RD_OPEN_VAL));
        wr_prot_d = ~wp_val;
        err_d     = !rd_ok || !(&wp_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_prot  <= 1'b0;
            wr_prot  <= '0;
            pair_err <= 1'b0;
        end else if (latch_stb) begin
            rd_prot  <= rd_prot_d;
            wr_prot  <= wr_prot_d;
            pair_err <= err_d;
        end
    end
endmodule

// File: rtl/optb_seq.sv
module optb_seq
    import optb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            dis_req,
    input  logic            pgm_ack,
    output logic            dis_busy,
    output logic            pgm_erase,
    output logic            pgm_write,
    output logic [HW_W-1:0] pgm_data
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (dis_req) state_d = ST_ERASE;
                ST_ERASE: if (pgm_ack) state_d = ST_WRITE;
                ST_WRITE: if (pgm_ack) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        dis_busy  = 1'b0;
        pgm_erase = 1'b0;
        pgm_write = 1'b0;
        pgm_data  = ERASED_HW;
        unique case (state_q)
            ST_IDLE: ;
            ST_ERASE: begin
                dis_busy  = 1'b1;
                pgm_erase = 1'b1;
            end
            ST_WRITE: begin
                dis_busy  = 1'b1;
                pgm_write = 1'b1;
                pgm_data  = pack_pair(RD_OPEN_VAL);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/optb_prot_unit.sv
module optb_prot_unit
    import optb_pkg::*;
#(
    parameter int NUM_WP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     latch_stb,
    input  logic [15:0]              rd_hw,
    input  logic [NUM_WP*16-1:0]     wp_hw,
    input  logic                     dis_req,
    input  logic                     pgm_ack,
    output logic                     rd_prot,
    output logic [NUM_WP*8-1:0]      wr_prot,
    output logic                     pair_err,
    output logic                     dis_busy,
    output logic                     pgm_erase,
    output logic                     pgm_write,
    output logic [15:0]              pgm_data
);
    localparam int WP_VAL_W = NUM_WP * BYTE_W;

    logic [BYTE_W-1:0]   rd_val;
    logic                rd_ok;
    logic [WP_VAL_W-1:0] wp_val;
    logic [NUM_WP-1:0]   wp_ok;

    optb_pair_decode u_rd_dec (
        .hw  (rd_hw),
        .val (rd_val),
        .ok  (rd_ok)
    );

    for (genvar k = 0; k < NUM_WP; k++) begin : g_wp_dec
        optb_pair_decode u_wp_dec (
            .hw  (wp_hw[k*HW_W +: HW_W]),
            .val (wp_val[k*BYTE_W +: BYTE_W]),
            .ok  (wp_ok[k])
        );
    end

    optb_latch #(.NUM_WP(NUM_WP)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_stb (latch_stb),
        .rd_val    (rd_val),
        .rd_ok     (rd_ok),
        .wp_val    (wp_val),
        .wp_ok     (wp_ok),
        .rd_prot   (rd_prot),
        .wr_prot   (wr_prot),
        .pair_err  (pair_err)
    );

    optb_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (latch_stb),
        .dis_req   (dis_req),
        .pgm_ack   (pgm_ack),
        .dis_busy  (dis_busy),
        .pgm_erase (pgm_erase),
        .pgm_write (pgm_write),
        .pgm_data  (pgm_data)
    );
endmodule

// File: rtl/optb_checker.sv
module optb_checker #(
    parameter int NUM_WP = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 latch_stb,
    input logic [15:0]          rd_hw,
    input logic                 dis_req,
    input logic                 pgm_ack,
    input logic                 rd_prot,
    input logic [NUM_WP*8-1:0]  wr_prot,
    input logic                 pair_err,
    input logic                 dis_busy,
    input logic                 pgm_erase,
    input logic                 pgm_write
);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_stb |=> ($stable(rd_prot) && $stable(wr_prot) && $stable(pair_err)));

    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && rd_hw == 16'h5AA5) |=> !rd_prot);

    p_erased_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && rd_hw == 16'hFFFF) |=> rd_prot);

    p_bad_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && rd_hw[15:8] != ~rd_hw[7:0] && rd_hw != 16'hFFFF) |=> (rd_prot && pair_err));

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_erase, pgm_write}));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_erase && pgm_ack && !latch_stb) |=> pgm_write);

    p_hold_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_erase && !pgm_ack && !latch_stb) |=> pgm_erase);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> (!dis_busy && !pgm_erase && !pgm_write));

    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_write && dis_req) |=> !pgm_erase);
endmodule

bind optb_prot_unit optb_checker #(.NUM_WP(NUM_WP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_stb (latch_stb),
    .rd_hw     (rd_hw),
    .dis_req   (dis_req),
    .pgm_ack   (pgm_ack),
    .rd_prot   (rd_prot),
    .wr_prot   (wr_prot),
    .pair_err  (pair_err),
    .dis_busy  (dis_busy),
    .pgm_erase (pgm_erase),
    .pgm_write (pgm_write)
);

// File: tb/sim_optb_prot_unit.sv
`timescale 1ns/1ps
module sim_optb_prot_unit;
    localparam int NWP = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            latch_stb = 1'b0;
    logic [15:0]     rd_hw = 16'hFFFF;
    logic [NWP*16-1:0] wp_hw = '1;
    logic            dis_req = 1'b0;
    logic            pgm_ack = 1'b0;
    logic            rd_prot;
    logic [NWP*8-1:0] wr_prot;
    logic            pair_err;
    logic            dis_busy;
    logic            pgm_erase;
    logic            pgm_write;
    logic [15:0]     pgm_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    optb_prot_unit #(.NUM_WP(NWP)) u0 (
        .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .rd_hw(rd_hw),
        .wp_hw(wp_hw), .dis_req(dis_req), .pgm_ack(pgm_ack),
        .rd_prot(rd_prot), .wr_prot(wr_prot), .pair_err(pair_err),
        .dis_busy(dis_busy), .pgm_erase(pgm_erase), .pgm_write(pgm_write),
        .pgm_data(pgm_data)
    );

    function automatic logic [15:0] pr(input logic [7:0] v);
        return {~v, v};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_latch(input logic [15:0] r, input logic [NWP*16-1:0] w);
        rd_hw = r;
        wp_hw = w;
        latch_stb = 1'b1;
        tick();
        latch_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 rd_prot", {31'd0, rd_prot}, 32'd0);
        chk("R6 wr_prot", {16'd0, wr_prot}, 32'd0);
        chk("R6 pair_err", {31'd0, pair_err}, 32'd0);
        chk("R7 idle busy", {29'd0, dis_busy, pgm_erase, pgm_write}, 32'd0);
    endtask

    task automatic t_no_latch();
        rd_hw = pr(8'h00);
        wp_hw = {pr(8'h00), 16'h1111};
        repeat (4) tick();
        chk("R5 no latch rd", {31'd0, rd_prot}, 32'd0);
        chk("R5 no latch wp", {16'd0, wr_prot}, 32'd0);
        chk("R5 no latch err", {31'd0, pair_err}, 32'd0);
    endtask

    task automatic t_decode();
        do_latch(16'h5AA5, {pr(8'h0F), pr(8'hF0)});
        chk("R2 open rd", {31'd0, rd_prot}, 32'd0);
        chk("R4 wp map", {16'd0, wr_prot}, 32'h0000F00F);
        chk("R1 clean err", {31'd0, pair_err}, 32'd0);
        do_latch(16'hFFFF, 32'hFFFF_FFFF);
        chk("R2 erased rd", {31'd0, rd_prot}, 32'd1);
        chk("R1 erased wp", {16'd0, wr_prot}, 32'd0);
        chk("R1 erased no err", {31'd0, pair_err}, 32'd0);
        do_latch(16'hFF00, 32'hFFFF_FFFF);
        chk("R2 zero rd", {31'd0, rd_prot}, 32'd1);
        do_latch(pr(8'h5A), 32'hFFFF_FFFF);
        chk("R2 other rd", {31'd0, rd_prot}, 32'd1);
    endtask

    task automatic t_mismatch();
        do_latch(16'h5AA4, 32'hFFFF_FFFF);
        chk("R3 rd mismatch prot", {31'd0, rd_prot}, 32'd1);
        chk("R3 rd mismatch err", {31'd0, pair_err}, 32'd1);
        do_latch(16'h5AA5, {16'h1234, pr(8'hFF)});
        chk("R4 wp mismatch bits", {16'd0, wr_prot}, 32'h0000FF00);
        chk("R4 wp mismatch err", {31'd0, pair_err}, 32'd1);
        chk("R4 rd still open", {31'd0, rd_prot}, 32'd0);
    endtask

    task automatic t_hold();
        do_latch(16'h5AA5, {pr(8'hAA), pr(8'h55)});
        rd_hw = 16'hFF00;
        wp_hw = 32'h0000_0000;
        repeat (3) tick();
        chk("R5 hold rd", {31'd0, rd_prot}, 32'd0);
        chk("R5 hold wp", {16'd0, wr_prot}, 32'h000055AA);
        chk("R5 hold err", {31'd0, pair_err}, 32'd0);
    endtask

    task automatic t_disable();
        dis_req = 1'b1;
        tick();
        dis_req = 1'b0;
        chk("R7 erase start", {30'd0, pgm_erase, pgm_write}, 32'd2);
        chk("R7 busy", {31'd0, dis_busy}, 32'd1);
        repeat (3) tick();
        chk("R7 erase held", {30'd0, pgm_erase, pgm_write}, 32'd2);
        pgm_ack = 1'b1;
        tick();
        pgm_ack = 1'b0;
        chk("R8 write only", {30'd0, pgm_erase, pgm_write}, 32'd1);
        chk("R7 write data", {16'd0, pgm_data}, 32'h00005AA5);
        dis_req = 1'b1;
        tick();
        dis_req = 1'b0;
        chk("R10 ignored req", {29'd0, dis_busy, pgm_erase, pgm_write}, 32'd5);
        pgm_ack = 1'b1;
        tick();
        pgm_ack = 1'b0;
        chk("R7 done idle", {29'd0, dis_busy, pgm_erase, pgm_write}, 32'd0);
        tick();
        chk("R10 no restart", {29'd0, dis_busy, pgm_erase, pgm_write}, 32'd0);
        do_latch(16'h5AA5, 32'hFFFF_FFFF);
        chk("R7 cleared rd", {31'd0, rd_prot}, 32'd0);
        chk("R7 cleared wp", {16'd0, wr_prot}, 32'd0);
    endtask

    task automatic t_abort();
        dis_req = 1'b1;
        tick();
        dis_req = 1'b0;
        chk("R7 erase again", {31'd0, pgm_erase}, 32'd1);
        do_latch(16'hFF00, 32'hFFFF_FFFF);
        chk("R9 aborted", {29'd0, dis_busy, pgm_erase, pgm_write}, 32'd0);
        chk("R9 latched rd", {31'd0, rd_prot}, 32'd1);
        repeat (2) tick();
        chk("R9 stays idle", {29'd0, dis_busy, pgm_erase, pgm_write}, 32'd0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_no_latch();
        t_decode();
        t_mismatch();
        t_hold();
        t_disable();
        t_abort();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule